// File: doc/BRIEF.md
# Oscillator Phase Argument Generator

This block produces the phase argument that feeds the sine/cosine stage of a quadrature numerically controlled oscillator. A wrapping phase accumulator advances every enabled clock by the sum of two tuning words, a center word and an offset word. The offset word can be suppressed at any time by a discrete input. Because only the step size changes and the accumulator keeps its value, the output moves between two frequencies without a phase jump.

After the accumulator, a 16-bit phase word is added to the upper half of the argument. A 3-bit modulation input is added to the top three bits, which gives eight evenly spaced phase steps for 8-level PSK. Neither addition feeds back into the accumulator. Software loads the tuning and phase words over a narrow write-only port into holding registers. Separate clock-sampled load inputs then copy each holding register into its active register, so every change takes effect on a known clock edge.

Top module: `nco_phase_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released with idle inputs, `phase_out` is zero and the accumulator, holding and active registers are all zero.
- R2: A port write happens on the clock where `cfg_wr_n` is first sampled high after being sampled low, with `cfg_cs_n` sampled low on that clock. Address 0 loads bits 15:0 of the center word and address 1 loads bits 31:16. Addresses 2 and 3 do the same for the offset word, and address 4 loads the phase word. Addresses 5 to 7 are ignored, and so is any strobe edge while `cfg_cs_n` is high.
- R3: A port write changes only a holding register. The active center, offset and phase registers take their holding values on a clock edge where `ld_cf_en`, `ld_of_en` or `ld_ph_en` respectively is high, and otherwise keep their value.
- R4: On each clock with `acc_en` high and `acc_init` low, the accumulator adds the increment modulo 2^32. The increment is the active center word plus the active offset word. With both inputs low, the accumulator holds.
- R5: While `ofs_inhibit` is high, the increment is the active center word alone.
- R6: A clock with `acc_init` high sets the accumulator to zero, whatever `acc_en` is.
- R7: The active phase word is added at bits 31:16 of the argument. It is added after the accumulator and never enters the accumulator.
- R8: `psk_sel` is sampled on each clock edge, and its value times 2^29 is added to the argument modulo 2^32.
- R9: `phase_out` is registered. It equals the accumulator value, the phase word term and the sampled PSK term as they stood after the previous clock edge.
- R10: Loading a new active offset or center word changes only the increment. The accumulated phase carries on from its current value, with no jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cs_n | input | 1 | Port select, active low |
| cfg_wr_n | input | 1 | Write strobe; a write happens on its rising edge |
| cfg_addr | input | 3 | Register address |
| cfg_data | input | 16 | Write data |
| ld_cf_en | input | 1 | Copy the center holding register to the active register |
| ld_of_en | input | 1 | Copy the offset holding register to the active register |
| ld_ph_en | input | 1 | Copy the phase holding register to the active register |
| acc_en | input | 1 | Let the accumulator advance |
| acc_init | input | 1 | Set the accumulator to zero |
| ofs_inhibit | input | 1 | Leave the offset word out of the increment |
| psk_sel | input | 3 | PSK phase step index |
| phase_out | output | 32 | Phase argument to the sine/cosine stage |

## Verification
The assertions assume that every control input is synchronous to `clk` and stays stable around the rising edge. They also assume that the write strobe is held low for at least one full clock, so that the edge detector sees both levels. The stimulus changes inputs only on the falling clock edge. Each write strobe lasts one whole cycle, with address, data and select held steady until the cycle after the strobe rises. Reset is released while all inputs are idle and the accumulator is disabled.

// File: rtl/nco_pfc_pkg.sv
package nco_pfc_pkg;
  // Port address map; the order sets which half of which word is written.
  typedef enum logic [2:0] {
    ADR_CF_LO = 3'd0,
    ADR_CF_HI = 3'd1,
    ADR_OF_LO = 3'd2,
    ADR_OF_HI = 3'd3,
    ADR_PH    = 3'd4
  } cfg_addr_e;

  localparam int DEF_FREQ_W = 32;
  localparam int DEF_DATA_W = 16;
  localparam int DEF_PH_W   = 16;
  localparam int DEF_PSK_W  = 3;
  localparam int DEF_ADDR_W = 3;
endpackage

// File: rtl/nco_pfc_regfile.sv
module nco_pfc_regfile #(
  parameter int FREQ_W = 32,
  parameter int DATA_W = 16,
  parameter int PH_W   = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic              ld_cf,
  input  logic              ld_of,
  input  logic              ld_ph,
  output logic [FREQ_W-1:0] cf_hold,
  output logic [FREQ_W-1:0] cf_act,
  output logic [FREQ_W-1:0] of_act,
  output logic [PH_W-1:0]   ph_act
);
  localparam int HALVES = FREQ_W / DATA_W;

  logic              wr_n_q;
  logic              wr_fire;
  logic [FREQ_W-1:0] cf_hold_q, cf_hold_d;
  logic [FREQ_W-1:0] of_hold_q, of_hold_d;
  logic [PH_W-1:0]   ph_hold_q, ph_hold_d;
  logic [FREQ_W-1:0] cf_act_q, cf_act_d;
  logic [FREQ_W-1:0] of_act_q, of_act_d;
  logic [PH_W-1:0]   ph_act_q, ph_act_d;

  assign wr_fire = wr_n & ~wr_n_q & ~cs_n;

  always_comb begin
    cf_hold_d = cf_hold_q;
    of_hold_d = of_hold_q;
    ph_hold_d = ph_hold_q;
    if (wr_fire) begin
      for (int h = 0; h < HALVES; h++) begin
        if (addr == ADDR_W'(h))
          cf_hold_d[h*DATA_W +: DATA_W] = data;
        if (addr == ADDR_W'(HALVES + h))
          of_hold_d[h*DATA_W +: DATA_W] = data;
      end
      if (addr == ADDR_W'(2*HALVES))
        ph_hold_d = data[PH_W-1:0];
    end
  end

  always_comb begin
    cf_act_d = ld_cf ? cf_hold_q : cf_act_q;
    of_act_d = ld_of ? of_hold_q : of_act_q;
    ph_act_d = ld_ph ? ph_hold_q : ph_act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_n_q    <= 1'b1;
      cf_hold_q <= '0;
      of_hold_q <= '0;
      ph_hold_q <= '0;
      cf_act_q  <= '0;
      of_act_q  <= '0;
      ph_act_q  <= '0;
    end else begin
      wr_n_q    <= wr_n;
      cf_hold_q <= cf_hold_d;
      of_hold_q <= of_hold_d;
      ph_hold_q <= ph_hold_d;
      cf_act_q  <= cf_act_d;
      of_act_q  <= of_act_d;
      ph_act_q  <= ph_act_d;
    end
  end

  assign cf_hold = cf_hold_q;
  assign cf_act  = cf_act_q;
  assign of_act  = of_act_q;
  assign ph_act  = ph_act_q;
endmodule

// File: rtl/nco_pfc_accum.sv
module nco_pfc_accum #(
  parameter int FREQ_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_en,
  input  logic              clr,
  input  logic              inhibit,
  input  logic [FREQ_W-1:0] cf,
  input  logic [FREQ_W-1:0] of,
  output logic [FREQ_W-1:0] acc
);
  logic [FREQ_W-1:0] step;
  logic [FREQ_W-1:0] acc_q, acc_d;

  assign step = cf + (inhibit ? '0 : of);

  always_comb begin
    if (clr)
      acc_d = '0;
    else if (adv_en)
      acc_d = acc_q + step;
    else
      acc_d = acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc = acc_q;
endmodule

// File: rtl/nco_pfc_phase_sum.sv
module nco_pfc_phase_sum #(
  parameter int FREQ_W = 32,
  parameter int PH_W   = 16,
  parameter int PSK_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FREQ_W-1:0] acc,
  input  logic [PH_W-1:0]   ph,
  input  logic [PSK_W-1:0]  psk,
  output logic [FREQ_W-1:0] arg
);
  localparam int PH_SH  = FREQ_W - PH_W;
  localparam int PSK_SH = FREQ_W - PSK_W;

  logic [PSK_W-1:0]  psk_q;
  logic [FREQ_W-1:0] ph_term, psk_term;
  logic [FREQ_W-1:0] arg_q, arg_d;

  assign ph_term  = {ph, {PH_SH{1'b0}}};
  assign psk_term = {psk_q, {PSK_SH{1'b0}}};
  assign arg_d    = acc + ph_term + psk_term;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psk_q <= '0;
      arg_q <= '0;
    end else begin
      psk_q <= psk;
      arg_q <= arg_d;
    end
  end

  assign arg = arg_q;
endmodule

// File: rtl/nco_phase_ctrl.sv
module nco_phase_ctrl
  import nco_pfc_pkg::*;
#(
  parameter int FREQ_W = DEF_FREQ_W,
  parameter int DATA_W = DEF_DATA_W,
  parameter int PH_W   = DEF_PH_W,
  parameter int PSK_W  = DEF_PSK_W,
  parameter int ADDR_W = DEF_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_cs_n,
  input  logic              cfg_wr_n,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_data,
  input  logic              ld_cf_en,
  input  logic              ld_of_en,
  input  logic              ld_ph_en,
  input  logic              acc_en,
  input  logic              acc_init,
  input  logic              ofs_inhibit,
  input  logic [PSK_W-1:0]  psk_sel,
  output logic [FREQ_W-1:0] phase_out
);
  logic              rst_meta_q, rst_sync_q;
  logic [FREQ_W-1:0] cf_hold, cf_act, of_act, acc;
  logic [PH_W-1:0]   ph_act;

  // Reset asserts at once and releases two clocks later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  nco_pfc_regfile #(
    .FREQ_W(FREQ_W), .DATA_W(DATA_W), .PH_W(PH_W), .ADDR_W(ADDR_W)
  ) regs_i (
    .clk(clk), .rst_n(rst_sync_q),
    .cs_n(cfg_cs_n), .wr_n(cfg_wr_n), .addr(cfg_addr), .data(cfg_data),
    .ld_cf(ld_cf_en), .ld_of(ld_of_en), .ld_ph(ld_ph_en),
    .cf_hold(cf_hold), .cf_act(cf_act), .of_act(of_act), .ph_act(ph_act)
  );

  nco_pfc_accum #(.FREQ_W(FREQ_W)) accum_i (
    .clk(clk), .rst_n(rst_sync_q),
    .adv_en(acc_en), .clr(acc_init), .inhibit(ofs_inhibit),
    .cf(cf_act), .of(of_act), .acc(acc)
  );

  nco_pfc_phase_sum #(
    .FREQ_W(FREQ_W), .PH_W(PH_W), .PSK_W(PSK_W)
  ) sum_i (
    .clk(clk), .rst_n(rst_sync_q),
    .acc(acc), .ph(ph_act), .psk(psk_sel), .arg(phase_out)
  );
endmodule

// File: rtl/nco_phase_ctrl_chk.sv
module nco_phase_ctrl_chk #(
  parameter int FREQ_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_en,
  input logic              acc_init,
  input logic              ofs_inhibit,
  input logic              ld_cf_en,
  input logic [FREQ_W-1:0] cf_hold,
  input logic [FREQ_W-1:0] cf_act,
  input logic [FREQ_W-1:0] acc
);
  assert_init_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_init |=> acc == '0);

  assert_acc_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_init && !acc_en) |=> $stable(acc));

  assert_center_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ld_cf_en |=> cf_act == $past(cf_hold));

  assert_center_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_cf_en |=> $stable(cf_act));

  assert_inhibit_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_init && acc_en && ofs_inhibit && !ld_cf_en)
      |=> acc == $past(acc) + cf_act);
endmodule

bind nco_phase_ctrl nco_phase_ctrl_chk #(.FREQ_W(FREQ_W)) chk_i (
  .clk(clk), .rst_n(rst_sync_q), .acc_en(acc_en), .acc_init(acc_init),
  .ofs_inhibit(ofs_inhibit), .ld_cf_en(ld_cf_en), .cf_hold(cf_hold),
  .cf_act(cf_act), .acc(acc)
);

// File: tb/nco_phase_ctrl_tb_top.sv
`timescale 1ns/1ps
module nco_phase_ctrl_tb_top;
  logic        clk;
  logic        rst_n;
  logic        cfg_cs_n, cfg_wr_n;
  logic [2:0]  cfg_addr;
  logic [15:0] cfg_data;
  logic        ld_cf_en, ld_of_en, ld_ph_en, acc_en, acc_init, ofs_inhibit;
  logic [2:0]  psk_sel;
  logic [31:0] phase_out;

  int checks = 0;
  int fails  = 0;
  string tag = "R1";

  nco_phase_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_cs_n(cfg_cs_n), .cfg_wr_n(cfg_wr_n),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .ld_cf_en(ld_cf_en),
    .ld_of_en(ld_of_en), .ld_ph_en(ld_ph_en), .acc_en(acc_en),
    .acc_init(acc_init), .ofs_inhibit(ofs_inhibit), .psk_sel(psk_sel),
    .phase_out(phase_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Reference model written from the requirements
  logic [31:0] m_cfh, m_ofh, m_cf, m_of, m_acc, m_out;
  logic [15:0] m_phh, m_ph;
  logic [2:0]  m_psk;
  logic        m_wrp;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cfh <= 0; m_ofh <= 0; m_phh <= 0; m_cf <= 0; m_of <= 0; m_ph <= 0;
      m_acc <= 0; m_out <= 0; m_psk <= 0; m_wrp <= 1'b1;
    end else begin
      m_wrp <= cfg_wr_n;
      if (cfg_wr_n && !m_wrp && !cfg_cs_n) begin
        case (cfg_addr)
          3'd0: m_cfh[15:0]  <= cfg_data;
          3'd1: m_cfh[31:16] <= cfg_data;
          3'd2: m_ofh[15:0]  <= cfg_data;
          3'd3: m_ofh[31:16] <= cfg_data;
          3'd4: m_phh        <= cfg_data;
          default: ;
        endcase
      end
      if (ld_cf_en) m_cf <= m_cfh;
      if (ld_of_en) m_of <= m_ofh;
      if (ld_ph_en) m_ph <= m_phh;
      if (acc_init)    m_acc <= 32'd0;
      else if (acc_en) m_acc <= m_acc + m_cf + (ofs_inhibit ? 32'd0 : m_of);
      m_psk <= psk_sel;
      m_out <= m_acc + {m_ph, 16'h0} + {m_psk, 29'h0};
    end
  end

  task automatic check(input logic [31:0] exp);
    checks++;
    if (phase_out !== exp) begin
      fails++;
      $display("FAIL %s: phase_out got %h expected %h", tag, phase_out, exp);
    end
  endtask

  // Wait for the falling edge, then compare with the model.
  task automatic tick();
    @(negedge clk);
    check(m_out);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d, input logic sel);
    tick();
    cfg_cs_n = ~sel; cfg_addr = a; cfg_data = d; cfg_wr_n = 1'b0;
    tick();
    cfg_wr_n = 1'b1;
    tick();
    cfg_cs_n = 1'b1;
  endtask

  task automatic load(input logic cf, input logic of, input logic ph);
    tick();
    ld_cf_en = cf; ld_of_en = of; ld_ph_en = ph;
    tick();
    ld_cf_en = 1'b0; ld_of_en = 1'b0; ld_ph_en = 1'b0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_cs_n = 1'b1; cfg_wr_n = 1'b1; cfg_addr = 0; cfg_data = 0;
    ld_cf_en = 0; ld_of_en = 0; ld_ph_en = 0; acc_en = 0; acc_init = 0;
    ofs_inhibit = 0; psk_sel = 0;
    repeat (3) @(negedge clk);
    tag = "R1"; check(32'd0);
    rst_n = 1'b1;
    run(4);
    check(32'd0);

    // R2 writes alone leave the output at zero; R3 holding only
    tag = "R2";
    wr(3'd0, 16'h0000, 1'b1);
    wr(3'd1, 16'h0100, 1'b1);
    wr(3'd3, 16'h0080, 1'b0);   // ignored: select high
    wr(3'd5, 16'hFFFF, 1'b1);   // ignored: unused address
    tag = "R3"; run(3); check(32'd0);
    tick(); acc_en = 1'b1;
    run(4); check(32'd0);       // active words still zero

    // R4 advance with the center word only
    tag = "R4";
    load(1'b1, 1'b1, 1'b1);
    run(20);

    // R10 switch in the offset word without a phase jump
    tag = "R10";
    wr(3'd2, 16'h0000, 1'b1);
    wr(3'd3, 16'h0080, 1'b1);
    load(1'b0, 1'b1, 1'b0);
    run(12);

    // R5 inhibit toggling
    tag = "R5";
    for (int k = 0; k < 6; k++) begin
      tick(); ofs_inhibit = k[0];
      run(3);
    end
    tick(); ofs_inhibit = 1'b0;

    // R6 clear has priority over advance
    tag = "R6";
    tick(); acc_init = 1'b1;
    tick(); acc_init = 1'b0;
    run(2); check(32'h0180_0000 * 1);
    tick(); acc_en = 1'b0; acc_init = 1'b1;
    tick(); acc_init = 1'b0;
    run(3); check(32'd0);

    // R7 phase word sweep with the accumulator stopped at zero
    tag = "R7";
    for (int v = 0; v < 16; v++) begin
      wr(3'd4, 16'(v * 16'h1111 + 16'h0001), 1'b1);
      load(1'b0, 1'b0, 1'b1);
      run(2); check({16'(v * 16'h1111 + 16'h0001), 16'h0000});
    end
    wr(3'd4, 16'h0000, 1'b1);
    load(1'b0, 1'b0, 1'b1);
    run(2);

    // R8 exhaustive PSK sweep
    tag = "R8";
    for (int p = 0; p < 8; p++) begin
      tick(); psk_sel = 3'(p);
      run(2); check({3'(p), 29'd0});
    end

    // R9 one-cycle registering of the PSK sample
    tag = "R9";
    tick(); psk_sel = 3'd2;
    @(negedge clk); checks++;
    if (phase_out !== {3'd7, 29'd0}) begin
      fails++;
      $display("FAIL R9: phase_out got %h expected %h", phase_out, {3'd7, 29'd0});
    end
    @(negedge clk); checks++;
    if (phase_out !== {3'd2, 29'd0}) begin
      fails++;
      $display("FAIL R9: phase_out got %h expected %h", phase_out, {3'd2, 29'd0});
    end

    // R4 wrap with a large center word plus PSK and phase terms
    tag = "R4";
    wr(3'd0, 16'h0001, 1'b1);
    wr(3'd1, 16'hC000, 1'b1);
    wr(3'd4, 16'hFFFF, 1'b1);
    load(1'b1, 1'b0, 1'b1);
    tick(); acc_en = 1'b1; psk_sel = 3'd5;
    run(30);
    tick(); acc_en = 1'b0;
    run(4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule